// File: doc/BRIEF.md
# Effective Address Sequencer

This block resolves the operand of a one-address instruction on a 16-bit accumulator machine. The only data type is the 16-bit word, and there are no register-direct modes. The caller presents an 8-bit mode byte and the operand word `m` together with a one-cycle `start`. The block returns one of three things: the operand itself (immediate), a final 16-bit effective address, or an illegal-mode flag. A one-cycle `done` marks the result. For the indirect forms the block fetches a pointer word from a single-port word memory. In the post-increment forms it then writes the unindexed pointer plus one back to the same location.

The mode byte is a bit field. Bit 0 must be 1 and bits 7:6 must be 0. Bit 1 selects immediate, bit 2 selects indirection through memory, and bit 3 selects the post-increment write-back. Bits 5:4 select the index added to the address: 00 none, 01 IX, 10 IY, 11 SP. Thirteen byte values are legal: 0x03, 0x01/0x11/0x21/0x31, 0x05/0x15/0x25/0x35 and 0x0D/0x1D/0x2D/0x3D. All other values are illegal. The index value is captured when `start` is accepted. All arithmetic wraps modulo 2^16.

Top module: `ea_sequencer`

## Requirements
- R1: Mode 0x03 (bit 1 set, bits 5:2 zero) drives `result` = `m` and `res_is_value` = 1, with `done` high in the first cycle after the accepting edge and no memory request.
- R2: Mode 0x01 drives `result` = `m` with `done` one cycle after the accepting edge, and no memory request.
- R3: Modes 0x11, 0x21 and 0x31 drive `result` = `m` + IX, IY or SP modulo 2^16, with `done` one cycle after the accepting edge and no memory request.
- R4: Mode 0x05 reads the word at address `m` (`mem_we` = 0), and that word becomes `result`. `done` follows 2 + W cycles after the accepting edge, where W is the number of cycles the read request waits for `mem_rdy`.
- R5: Modes 0x15, 0x25 and 0x35 read the pointer at `m`, and `result` = pointer + selected index, modulo 2^16.
- R6: Modes 0x0D, 0x1D, 0x2D and 0x3D read the pointer at `m`, and `result` = pointer + index (none for 0x0D). The read completes first. The block then writes pointer + 1 (unindexed, modulo 2^16) to address `m`. `done` follows 3 + Wr + Ww cycles after the accepting edge, where Wr and Ww are the wait cycles of the read and of the write.
- R7: Any other mode byte sets `bad_mode` with `done` one cycle after the accepting edge. It raises no memory request and leaves memory unchanged.
- R8: While `mem_req` is high and `mem_rdy` is low, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R9: `start` is ignored while `busy` is high, and the operation in progress completes unchanged.
- R10: Synchronous active-high `rst` returns the block to idle. In the cycle after, `mem_req`, `done` and `busy` are low and `result` is zero.
- R11: `done` lasts exactly one cycle. `result`, `res_is_value` and `bad_mode` hold until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin resolving; accepted only when idle |
| mode | input | 8 | Addressing-mode byte |
| opnd | input | 16 | Operand word m |
| ix | input | 16 | Index register IX |
| iy | input | 16 | Index register IY |
| sp | input | 16 | Stack pointer |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory completes the access this cycle |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 16 | Operand value or effective address |
| res_is_value | output | 1 | Result is the immediate operand |
| bad_mode | output | 1 | Mode byte was illegal |

## Verification
Immediate, direct, direct-indexed and illegal modes are due at the first falling edge after the accepting rising edge. Indirect modes are due 2 + W falling edges after it, and post-increment modes 3 + Wr + Ww. The bench memory inserts a programmable number of wait cycles per access. The bench counts falling edges from `start` until `done`, compares the count with that formula, and only then compares the result, the flags and the memory word at `m`. While waiting, it records every bus cycle, so it can check that requests are present or absent, that writes are ordered after reads, and that the bus holds steady during wait states.

// File: rtl/ea_seq_pkg.sv
package ea_seq_pkg;

  typedef struct packed {
    logic       legal;
    logic       imm;
    logic       ind;
    logic       pinc;
    logic [1:0] idx;
  } mode_dec_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_WR   = 2'd2
  } seq_state_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_seq_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic [MODE_W-1:0] mode,
  output mode_dec_t         dec
);

  localparam int HI_W = MODE_W - 6;

  logic hi_zero;
  logic bit_mem, bit_imm, bit_ind, bit_pinc;

  assign hi_zero  = (mode[MODE_W-1:6] == {HI_W{1'b0}});
  assign bit_mem  = mode[0];
  assign bit_imm  = mode[1];
  assign bit_ind  = mode[2];
  assign bit_pinc = mode[3];

  always_comb begin
    dec.imm  = bit_imm;
    dec.ind  = bit_ind;
    dec.pinc = bit_pinc;
    dec.idx  = mode[5:4];
    if (!hi_zero || !bit_mem) begin
      dec.legal = 1'b0;
    end else if (bit_imm) begin
      dec.legal = (mode[5:2] == 4'd0);
    end else begin
      dec.legal = !(bit_pinc && !bit_ind);
    end
  end

endmodule

// File: rtl/ea_index_sel.sv
module ea_index_sel #(
  parameter int DATA_W  = 16,
  parameter int NUM_IDX = 4,
  localparam int SEL_W  = $clog2(NUM_IDX)
) (
  input  logic [(NUM_IDX-1)*DATA_W-1:0] idx_regs,
  input  logic [SEL_W-1:0]              sel,
  output logic [DATA_W-1:0]             idx_val
);

  logic [DATA_W-1:0] bank [NUM_IDX];

  assign bank[0] = '0;

  for (genvar g = 1; g < NUM_IDX; g++) begin : g_bank
    assign bank[g] = idx_regs[(g-1)*DATA_W +: DATA_W];
  end

  assign idx_val = bank[sel];

endmodule

// File: rtl/ea_sequencer.sv
module ea_sequencer
  import ea_seq_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MODE_W  = 8,
  parameter int NUM_IDX = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] ix,
  input  logic [DATA_W-1:0] iy,
  input  logic [DATA_W-1:0] sp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rdy,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              res_is_value,
  output logic              bad_mode
);

  localparam int SEL_W = $clog2(NUM_IDX);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  seq_state_t        state;
  mode_dec_t         dec;
  logic [DATA_W-1:0] idx_live;
  logic [DATA_W-1:0] idx_q;
  logic              pinc_q;
  logic [DATA_W-1:0] add_base;
  logic [DATA_W-1:0] add_off;
  logic [DATA_W-1:0] add_sum;
  logic [DATA_W-1:0] ptr_next;
  logic              accept;

  ea_mode_decode #(.MODE_W(MODE_W)) u_dec (
    .mode (mode),
    .dec  (dec)
  );

  ea_index_sel #(.DATA_W(DATA_W), .NUM_IDX(NUM_IDX)) u_idx (
    .idx_regs ({sp, iy, ix}),
    .sel      (dec.idx[SEL_W-1:0]),
    .idx_val  (idx_live)
  );

  assign accept   = start && (state == S_IDLE);
  assign add_base = (state == S_IDLE) ? opnd : mem_rdata;
  assign add_off  = (state == S_IDLE) ? idx_live : idx_q;
  assign add_sum  = add_base + add_off;
  assign ptr_next = mem_rdata + ONE;
  assign busy     = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      done         <= 1'b0;
      result       <= '0;
      res_is_value <= 1'b0;
      bad_mode     <= 1'b0;
      idx_q        <= '0;
      pinc_q       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            res_is_value <= 1'b0;
            bad_mode     <= 1'b0;
            if (!dec.legal) begin
              bad_mode <= 1'b1;
              result   <= '0;
              done     <= 1'b1;
            end else if (dec.imm) begin
              result       <= opnd;
              res_is_value <= 1'b1;
              done         <= 1'b1;
            end else if (!dec.ind) begin
              result <= add_sum;
              done   <= 1'b1;
            end else begin
              state    <= S_RD;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= opnd;
              idx_q    <= idx_live;
              pinc_q   <= dec.pinc;
            end
          end
        end
        S_RD: begin
          if (mem_rdy) begin
            result <= add_sum;
            if (pinc_q) begin
              state     <= S_WR;
              mem_we    <= 1'b1;
              mem_wdata <= ptr_next;
            end else begin
              state   <= S_IDLE;
              mem_req <= 1'b0;
              done    <= 1'b1;
            end
          end
        end
        S_WR: begin
          if (mem_rdy) begin
            state   <= S_IDLE;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
          end
        end
        default: begin
          state   <= S_IDLE;
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
        end
      endcase
    end
  end

  // R10: reset leaves the block idle with the bus released
  a_r10_reset_idle: assert property (@(posedge clk)
    rst |=> (!mem_req && !done && !busy));

  // R8: bus fields hold during wait states
  a_r8_bus_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R6: a write only starts right after a completed read
  a_r6_read_before_write: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_req && mem_rdy && !mem_we));

  // R1: immediate operand is returned next cycle with no bus traffic
  a_r1_imm_value: assert property (@(posedge clk) disable iff (rst)
    (accept && dec.legal && dec.imm) |=>
      (done && res_is_value && !mem_req && result == $past(opnd)));

  // R7: illegal byte completes with the flag and without a request
  a_r7_illegal_no_bus: assert property (@(posedge clk) disable iff (rst)
    (accept && !dec.legal) |=> (done && bad_mode && !mem_req));

  // R11: done is a single-cycle strobe
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a start while busy does not restart the bus address
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_req && !mem_rdy && start) |=> $stable(mem_addr));

endmodule

// File: tb/ea_sequencer_bench.sv
`timescale 1ns/1ps
module ea_sequencer_bench;

  localparam int NV = 22;
  localparam logic [15:0] IXV = 16'h1000;
  localparam logic [15:0] IYV = 16'h2000;
  localparam logic [15:0] SPV = 16'hFFF0;

  // {mode, m, preloaded pointer, read/write wait cycles}
  localparam logic [41:0] VEC [NV] = '{
    {8'h03, 16'h1234, 16'h0000, 2'd0},
    {8'h01, 16'h0040, 16'h0000, 2'd0},
    {8'h11, 16'h0040, 16'h0000, 2'd0},
    {8'h21, 16'h0040, 16'h0000, 2'd0},
    {8'h31, 16'h0040, 16'h0000, 2'd0},
    {8'h05, 16'h0010, 16'hABCD, 2'd0},
    {8'h05, 16'h0011, 16'h0102, 2'd2},
    {8'h15, 16'h0012, 16'h0300, 2'd0},
    {8'h25, 16'h0013, 16'h0400, 2'd1},
    {8'h35, 16'h0014, 16'h0020, 2'd0},
    {8'h0D, 16'h0018, 16'hFFFF, 2'd0},
    {8'h1D, 16'h0019, 16'h0500, 2'd1},
    {8'h2D, 16'h001A, 16'h0600, 2'd2},
    {8'h3D, 16'h001B, 16'h0700, 2'd0},
    {8'h07, 16'h0020, 16'h1111, 2'd0},
    {8'h09, 16'h0021, 16'h2222, 2'd0},
    {8'h0B, 16'h0022, 16'h3333, 2'd0},
    {8'h13, 16'h0023, 16'h4444, 2'd0},
    {8'h43, 16'h0024, 16'h5555, 2'd0},
    {8'h00, 16'h0025, 16'h6666, 2'd0},
    {8'h1F, 16'h0026, 16'h7777, 2'd0},
    {8'h45, 16'h0027, 16'h8888, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  mode = 8'h00;
  logic [15:0] opnd = 16'h0000;
  logic        mem_req, mem_we, mem_rdy, busy, done, res_is_value, bad_mode;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, result;

  logic [15:0] mem [256];
  logic [1:0]  wait_cfg = 2'd0;
  logic [1:0]  wcnt = 2'd0;
  logic        pl_en = 1'b0;
  logic [7:0]  pl_addr = 8'h00;
  logic [15:0] pl_data = 16'h0000;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ea_sequencer u_ea_sequencer (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opnd(opnd),
    .ix(IXV), .iy(IYV), .sp(SPV),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .done(done), .result(result),
    .res_is_value(res_is_value), .bad_mode(bad_mode)
  );

  assign mem_rdy   = mem_req && (wcnt >= wait_cfg);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (pl_en) mem[pl_addr] <= pl_data;
    if (mem_req && mem_rdy && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_req && !mem_rdy) wcnt <= wcnt + 2'd1;
    else wcnt <= 2'd0;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  // Runs one operation from a falling edge; intrude pulses a stray start while busy
  task automatic run_op(input logic [7:0] md, input logic [15:0] m,
                        input logic [15:0] ptr, input logic [1:0] w,
                        input bit intrude);
    bit legal, imm, ind, pinc, seen_req, wrote, prev_hold, stab_ok;
    logic [15:0] idxv, exp_res, wr_addr, wr_data, p_addr, p_wdata;
    logic p_we;
    int exp_lat, cnt;
    string tag;
    legal = (md[7:6] == 2'b00) && md[0] &&
            (md[1] ? (md[5:2] == 4'd0) : !(md[3] && !md[2]));
    imm  = md[1];
    ind  = md[2];
    pinc = md[3];
    case (md[5:4])
      2'd0: idxv = 16'h0000;
      2'd1: idxv = IXV;
      2'd2: idxv = IYV;
      default: idxv = SPV;
    endcase
    if (!legal)      begin tag = "R7"; exp_res = 16'h0000;   exp_lat = 1; end
    else if (imm)    begin tag = "R1"; exp_res = m;          exp_lat = 1; end
    else if (!ind)   begin tag = (md[5:4] == 2'd0) ? "R2" : "R3";
                           exp_res = m + idxv;               exp_lat = 1; end
    else if (!pinc)  begin tag = (md[5:4] == 2'd0) ? "R4" : "R5";
                           exp_res = ptr + idxv;             exp_lat = 2 + int'(w); end
    else             begin tag = "R6"; exp_res = ptr + idxv; exp_lat = 3 + 2 * int'(w); end

    preload(m[7:0], ptr);
    wait_cfg = w;
    mode = md; opnd = m; start = 1'b1;
    cnt = 0; seen_req = 0; wrote = 0; prev_hold = 0; stab_ok = 1;
    wr_addr = '0; wr_data = '0; p_addr = '0; p_wdata = '0; p_we = 0;
    while (1) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        start = 1'b0;
        if (intrude) begin start = 1'b1; mode = 8'h03; opnd = 16'h9999; end
      end else if (cnt == 2) begin
        start = 1'b0;
      end
      if (prev_hold && !(mem_req && mem_addr == p_addr && mem_we == p_we &&
                         mem_wdata == p_wdata)) stab_ok = 0;
      prev_hold = mem_req && !mem_rdy;
      p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
      if (mem_req) seen_req = 1;
      if (mem_req && mem_we && mem_rdy) begin
        wrote = 1; wr_addr = mem_addr; wr_data = mem_wdata;
      end
      if (done || cnt > 40) break;
    end
    chk(done && cnt == exp_lat, tag, "latency", cnt, exp_lat);
    chk(result == exp_res, tag, "result", result, exp_res);
    chk(res_is_value == (legal && imm) && bad_mode == !legal, tag, "flags",
        {res_is_value, bad_mode}, {(legal && imm), !legal});
    chk(seen_req == (legal && !imm && ind), tag, "request seen",
        seen_req, (legal && !imm && ind));
    if (legal && !imm && ind && pinc) begin
      chk(wrote && wr_addr == m && wr_data == ptr + 16'h1, "R6", "writeback",
          {wr_addr, wr_data}, {m, ptr + 16'h1});
      chk(mem[m[7:0]] == ptr + 16'h1, "R6", "memory word", mem[m[7:0]], ptr + 16'h1);
    end else begin
      chk(!wrote && mem[m[7:0]] == ptr, tag, "memory unchanged", mem[m[7:0]], ptr);
    end
    if (w != 0) chk(stab_ok, "R8", "bus hold in wait", stab_ok, 1);
    @(negedge clk);
    chk(!done, "R11", "done one cycle", done, 0);
    chk(result == exp_res, "R11", "result held", result, exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: state right after reset
    chk(!mem_req && !done && !busy && result == 16'h0, "R10", "reset state",
        {mem_req, done, busy, result}, 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][41:34], VEC[i][33:18], VEC[i][17:2], VEC[i][1:0], 1'b0);
    end

    // R9: stray start while a post-increment sequence is in flight
    run_op(8'h0D, 16'h0030, 16'h0007, 2'd2, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(!done && !busy, "R9", "no restart after stray start", {done, busy}, 0);
    end

    // R10: reset in the middle of a read
    preload(8'h31, 16'h4242);
    wait_cfg = 2'd3;
    mode = 8'h05; opnd = 16'h0031; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && mem_req, "R10", "busy before reset", {busy, mem_req}, 2'b11);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!mem_req && !busy && !done && result == 16'h0, "R10", "reset mid-read",
        {mem_req, busy, done, result}, 0);

    // R1: immediate works straight after the aborted sequence
    run_op(8'h03, 16'hFFFF, 16'h0000, 2'd0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule